// File: doc/BRIEF.md
# Command-Driven FPGA Configuration Loader

This controller sits between a byte-wide link port and the slave 8-bit parallel configuration port of a target FPGA. Link traffic arrives as 32-bit words, one byte per handshake, least-significant byte first. While the controller owns the link it reads every word in full and looks for two command words: a start key and an end key. Any other word is dropped.

A start key clears the target by pulling the program pin low until the init pin answers low. The controller then releases program and waits for init to return high. After that it drives chip-select and write low and streams every following link byte, unchanged, onto the data port. Each byte gets one configuration-clock pulse. When the done pin rises, the indicator turns on, the parallel port is disabled, and the controller waits for the end key. The end key hands the link over and releases the held reset of the user FPGA.

A board-wide reset, or a falling edge on a separate reconfiguration request line, restarts the whole sequence. Only the board-wide reset touches other modules on the board. A timeout on the init handshake sets an error flag and returns the controller to waiting for a start key.

Top module: `cfg_loader`

## Requirements
- R1: A link word is built from four accepted bytes; the first byte fills bits 7:0 and the fourth fills bits 31:24. The same key bytes sent most-significant first do not match.
- R2: While hunting, every word is consumed in full. A word that is not a key causes no pin change. Key bytes that straddle a word boundary do not match.
- R3: After the start key, prog_no is low and lnk_ready_o is low until init_ni is low. Then prog_no returns high, and the controller waits with cs_no high until init_ni is high.
- R4: From the cycle after init_ni returns high, cs_no and wr_no stay low for the whole streaming phase.
- R5: Each streamed byte appears unchanged on cfg_data_o one cycle before cclk_o rises. cclk_o is high for exactly one cycle. Key patterns inside the stream are passed through and have no effect.
- R6: When done_i is high and no byte is in flight, cfg_led_o goes high, cs_no and wr_no go high, and the controller hunts for the end key. Other words are dropped.
- R7: The end key sets user_rst_no high, sets lnk_owned_o low and holds lnk_ready_o low.
- R8: After power-up reset, or in the cycle after glb_rst_ni is sampled low, the controller is hunting for the start key. In that state user_rst_no is low, lnk_owned_o is high, lnk_ready_o is high, prog_no is high and cfg_led_o is low.
- R9: A falling edge on reconf_req_i has the effect of R8 from any state, including mid-handshake. A start key sent afterwards is recognised.
- R10: If init_ni does not answer within TIMEOUT_CYC cycles of waiting, err_o goes high and the controller hunts for the start key again. The next start key clears err_o.
- R11: An end key received while hunting for the start key is dropped and does not release user_rst_no.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Power-up reset, active low, asynchronous |
| glb_rst_ni | input | 1 | Board-wide reset, active low, sampled synchronously |
| reconf_req_i | input | 1 | Reconfiguration request; a falling edge restarts |
| lnk_data_i | input | 8 | Link byte |
| lnk_valid_i | input | 1 | Link byte valid |
| lnk_ready_o | output | 1 | Link byte accepted when high together with valid |
| lnk_owned_o | output | 1 | High while the controller owns the link |
| prog_no | output | 1 | Target program pin, active low |
| init_ni | input | 1 | Target init pin, active low |
| cs_no | output | 1 | Target chip-select, active low |
| wr_no | output | 1 | Target write strobe, active low |
| cclk_o | output | 1 | Target configuration clock |
| cfg_data_o | output | 8 | Target configuration data |
| done_i | input | 1 | Target done pin |
| user_rst_no | output | 1 | Held reset to the user FPGA design, active low |
| cfg_led_o | output | 1 | Configured indicator |
| err_o | output | 1 | Init handshake timeout flag |

## Verification
The hardest cases are those where a restart or a timeout lands in the middle of the init handshake. From the ports, the only way to hold the controller there is to send a start key and then hold the emulated init pin still. The bench does exactly that: it holds init_ni high long enough to expire the timer, or drops reconf_req_i while the controller is waiting for init to return high. It then sends a fresh start key to show that the link was taken back with its word alignment reset. Misaligned and byte-reversed keys exercise word framing, which no single-word test would reach.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic [2:0] {
    ST_HUNT_START,
    ST_PROG,
    ST_INIT,
    ST_STREAM,
    ST_HUNT_END,
    ST_RELEASED
  } cfg_st_e;
endpackage

// File: rtl/cfg_word_asm.sv
module cfg_word_asm #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              take_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [WORD_W-1:0] word_o,
  output logic              last_o
);
  localparam int NB = WORD_W / BYTE_W;
  localparam int CW = (NB > 1) ? $clog2(NB) : 1;

  logic [WORD_W-BYTE_W-1:0] sh_q;
  logic [CW-1:0]            cnt_q;

  // newest byte lands on top; after NB bytes the first one sits at bit 0
  assign word_o = {byte_i, sh_q};
  assign last_o = take_i && (cnt_q == CW'(NB - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (take_i) begin
      sh_q  <= word_o[WORD_W-1:BYTE_W];
      cnt_q <= last_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_byte_feed.sv
module cfg_byte_feed #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              ready_o,
  output logic              idle_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              cclk_o
);
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_HIGH} ph_e;
  ph_e ph_q;

  assign idle_o  = (ph_q == PH_IDLE);
  assign ready_o = en_i && idle_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      data_o <= '0;
      cclk_o <= 1'b0;
    end else if (!en_i) begin
      ph_q   <= PH_IDLE;
      cclk_o <= 1'b0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (valid_i) begin
          data_o <= byte_i;
          ph_q   <= PH_SETUP;
        end
        PH_SETUP: begin
          cclk_o <= 1'b1;
          ph_q   <= PH_HIGH;
        end
        PH_HIGH: begin
          cclk_o <= 1'b0;
          ph_q   <= PH_IDLE;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int               WORD_W      = 32,
  parameter int               BYTE_W      = 8,
  parameter logic [WORD_W-1:0] START_KEY  = 32'hC0F1_6A5A,
  parameter logic [WORD_W-1:0] END_KEY    = 32'h0E0D_D00E,
  parameter int               TIMEOUT_CYC = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              glb_rst_ni,
  input  logic              reconf_req_i,
  input  logic [BYTE_W-1:0] lnk_data_i,
  input  logic              lnk_valid_i,
  output logic              lnk_ready_o,
  output logic              lnk_owned_o,
  output logic              prog_no,
  input  logic              init_ni,
  output logic              cs_no,
  output logic              wr_no,
  output logic              cclk_o,
  output logic [BYTE_W-1:0] cfg_data_o,
  input  logic              done_i,
  output logic              user_rst_no,
  output logic              cfg_led_o,
  output logic              err_o
);
  cfg_st_e st_q, st_d;
  logic reconf_q, restart, hunting, waiting;
  logic [WORD_W-1:0] word;
  logic word_last, feed_ready, feed_idle, feed_en, tmo_hit, tmo_fire, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reconf_q <= 1'b1;
    else         reconf_q <= reconf_req_i;
  end

  assign restart = !glb_rst_ni || (reconf_q && !reconf_req_i);
  assign hunting = (st_q == ST_HUNT_START) || (st_q == ST_HUNT_END);
  assign waiting = (st_q == ST_PROG) || (st_q == ST_INIT);
  assign feed_en = (st_q == ST_STREAM) && !restart;

  cfg_word_asm #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_asm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart || !hunting),
    .take_i (hunting && lnk_valid_i),
    .byte_i (lnk_data_i),
    .word_o (word),
    .last_o (word_last)
  );

  // done_i blocks a new byte so the last pulse completes before the port closes
  cfg_byte_feed #(.BYTE_W(BYTE_W)) u_feed (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (feed_en),
    .valid_i (lnk_valid_i && !done_i),
    .byte_i  (lnk_data_i),
    .ready_o (feed_ready),
    .idle_o  (feed_idle),
    .data_o  (cfg_data_o),
    .cclk_o  (cclk_o)
  );

  generate
    if (TIMEOUT_CYC > 0) begin : g_tmo
      localparam int TW = $clog2(TIMEOUT_CYC + 1);
      logic [TW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          cnt_q <= '0;
        else if (!waiting || st_d != st_q)    cnt_q <= '0;
        else                                  cnt_q <= cnt_q + 1'b1;
      end
      assign tmo_hit = waiting && (cnt_q == TW'(TIMEOUT_CYC - 1));
    end else begin : g_no_tmo
      assign tmo_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    st_d     = st_q;
    tmo_fire = 1'b0;
    unique case (st_q)
      ST_HUNT_START: if (word_last && word == START_KEY) st_d = ST_PROG;
      ST_PROG: begin
        if (!init_ni)     st_d = ST_INIT;
        else if (tmo_hit) begin st_d = ST_HUNT_START; tmo_fire = 1'b1; end
      end
      ST_INIT: begin
        if (init_ni)      st_d = ST_STREAM;
        else if (tmo_hit) begin st_d = ST_HUNT_START; tmo_fire = 1'b1; end
      end
      ST_STREAM:   if (done_i && feed_idle) st_d = ST_HUNT_END;
      ST_HUNT_END: if (word_last && word == END_KEY) st_d = ST_RELEASED;
      ST_RELEASED: st_d = ST_RELEASED;
      default:     st_d = ST_HUNT_START;
    endcase
    if (restart) begin
      st_d     = ST_HUNT_START;
      tmo_fire = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_HUNT_START;
      err_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (restart || (st_q == ST_HUNT_START && st_d == ST_PROG)) err_q <= 1'b0;
      else if (tmo_fire)                                         err_q <= 1'b1;
    end
  end

  always_comb begin
    if (hunting)                 lnk_ready_o = 1'b1;
    else if (st_q == ST_STREAM)  lnk_ready_o = feed_ready && !done_i;
    else                         lnk_ready_o = 1'b0;
  end

  assign prog_no     = (st_q != ST_PROG);
  assign cs_no       = (st_q != ST_STREAM);
  assign wr_no       = (st_q != ST_STREAM);
  assign user_rst_no = (st_q == ST_RELEASED);
  assign lnk_owned_o = (st_q != ST_RELEASED);
  assign cfg_led_o   = (st_q == ST_HUNT_END) || (st_q == ST_RELEASED);
  assign err_o       = err_q;
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              glb_rst_ni,
  input logic              reconf_req_i,
  input logic              lnk_ready_o,
  input logic              lnk_owned_o,
  input logic              prog_no,
  input logic              cs_no,
  input logic              wr_no,
  input logic              cclk_o,
  input logic [BYTE_W-1:0] cfg_data_o,
  input logic              done_i,
  input logic              user_rst_no,
  input logic              cfg_led_o
);
  assert_prog_stall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_no |-> (!lnk_ready_o && cs_no));

  assert_stream_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && !done_i && glb_rst_ni && !$fell(reconf_req_i)) |=> (!cs_no && !wr_no));

  assert_cclk_setup_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cclk_o) |-> ($stable(cfg_data_o) && !cs_no && !wr_no));

  assert_cclk_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cclk_o |=> !cclk_o);

  assert_port_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_led_o |-> (cs_no && wr_no && prog_no && !cclk_o));

  assert_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    user_rst_no |-> (!lnk_owned_o && !lnk_ready_o && cfg_led_o));

  assert_glb_rst_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_rst_ni |=> (!user_rst_no && lnk_owned_o && prog_no && lnk_ready_o));

  assert_reconf_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(reconf_req_i) |=> (!user_rst_no && lnk_owned_o && !cfg_led_o));
endmodule

bind cfg_loader cfg_loader_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .glb_rst_ni   (glb_rst_ni),
  .reconf_req_i (reconf_req_i),
  .lnk_ready_o  (lnk_ready_o),
  .lnk_owned_o  (lnk_owned_o),
  .prog_no      (prog_no),
  .cs_no        (cs_no),
  .wr_no        (wr_no),
  .cclk_o       (cclk_o),
  .cfg_data_o   (cfg_data_o),
  .done_i       (done_i),
  .user_rst_no  (user_rst_no),
  .cfg_led_o    (cfg_led_o)
);

// File: tb/sim_cfg_loader.sv
`timescale 1ns/1ps
module sim_cfg_loader;
  localparam logic [31:0] SKEY = 32'hC0F1_6A5A;
  localparam logic [31:0] EKEY = 32'h0E0D_D00E;
  localparam int TMO = 40;

  logic clk = 1'b0, rst_ni = 1'b0, glb_rst_ni = 1'b1, reconf_req_i = 1'b1;
  logic [7:0] lnk_data_i = '0;
  logic lnk_valid_i = 1'b0, init_ni = 1'b1, done_i = 1'b0;
  logic lnk_ready_o, lnk_owned_o, prog_no, cs_no, wr_no, cclk_o, user_rst_no, cfg_led_o, err_o;
  logic [7:0] cfg_data_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cfg_loader #(.START_KEY(SKEY), .END_KEY(EKEY), .TIMEOUT_CYC(TMO)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .glb_rst_ni(glb_rst_ni), .reconf_req_i(reconf_req_i),
    .lnk_data_i(lnk_data_i), .lnk_valid_i(lnk_valid_i), .lnk_ready_o(lnk_ready_o),
    .lnk_owned_o(lnk_owned_o), .prog_no(prog_no), .init_ni(init_ni), .cs_no(cs_no),
    .wr_no(wr_no), .cclk_o(cclk_o), .cfg_data_o(cfg_data_o), .done_i(done_i),
    .user_rst_no(user_rst_no), .cfg_led_o(cfg_led_o), .err_o(err_o)
  );

  // capture monitor for configuration clock pulses
  logic [7:0] cap [0:63];
  int cap_n = 0, mon_bad = 0;
  logic prev_cclk = 1'b0;
  logic [7:0] prev_data = '0;
  always @(negedge clk) begin
    if (cclk_o && !prev_cclk) begin
      if (cap_n < 64) cap[cap_n] = cfg_data_o;
      cap_n++;
      if (cfg_data_o !== prev_data || cs_no !== 1'b0 || wr_no !== 1'b0) mon_bad++;
    end
    if (prev_cclk && cclk_o) mon_bad++;
    prev_cclk = cclk_o;
    prev_data = cfg_data_o;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    lnk_data_i  = b;
    lnk_valid_i = 1'b1;
    while (!lnk_ready_o) @(negedge clk);
    @(negedge clk);
    lnk_valid_i = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int i = 0; i < 4; i++) send_byte(w[8*i +: 8]);
  endtask

  task automatic pulse_glb();
    @(negedge clk);
    glb_rst_ni = 1'b0;
    @(negedge clk);
    glb_rst_ni = 1'b1;
    done_i     = 1'b0;
    init_ni    = 1'b1;
  endtask

  task automatic go_stream();
    send_word(SKEY);
    chk("R3 prog low after start key", prog_no, 1'b0);
    chk("R3 link stalled", lnk_ready_o, 1'b0);
    repeat (3) @(negedge clk);
    chk("R3 prog held until init low", prog_no, 1'b0);
    init_ni = 1'b0;
    @(negedge clk);
    chk("R3 prog released", prog_no, 1'b1);
    chk("R3 cs high while init low", cs_no, 1'b1);
    repeat (2) @(negedge clk);
    chk("R3 still waiting", cs_no, 1'b1);
    init_ni = 1'b1;
    @(negedge clk);
    chk("R4 cs low", cs_no, 1'b0);
    chk("R4 wr low", wr_no, 1'b0);
  endtask

  task automatic reach_release();
    go_stream();
    send_byte(8'h11);
    send_byte(8'h22);
    repeat (4) @(negedge clk);
    done_i = 1'b1;
    @(negedge clk);
    send_word(EKEY);
    chk("R7 released", user_rst_no, 1'b1);
  endtask

  task automatic t_reset();
    chk("R8 reset prog", prog_no, 1'b1);
    chk("R8 reset cs", cs_no, 1'b1);
    chk("R8 reset cclk", cclk_o, 1'b0);
    chk("R8 reset user rst", user_rst_no, 1'b0);
    chk("R8 reset owned", lnk_owned_o, 1'b1);
    chk("R8 reset ready", lnk_ready_o, 1'b1);
    chk("R8 reset led", cfg_led_o, 1'b0);
    chk("R10 reset err", err_o, 1'b0);
  endtask

  task automatic t_framing();
    send_word(32'h1234_5678);
    chk("R2 junk word dropped", prog_no, 1'b1);
    chk("R2 still ready", lnk_ready_o, 1'b1);
    send_word(EKEY);
    chk("R11 end key ignored", user_rst_no, 1'b0);
    chk("R11 still owned", lnk_owned_o, 1'b1);
    send_word({SKEY[7:0], SKEY[15:8], SKEY[23:16], SKEY[31:24]});
    chk("R1 reversed bytes no match", prog_no, 1'b1);
    send_byte(8'h99);
    send_word(SKEY);
    for (int i = 0; i < 3; i++) send_byte(8'h77);
    chk("R2 misaligned key no match", prog_no, 1'b1);
    send_word(SKEY);
    chk("R1 aligned key matches", prog_no, 1'b0);
    pulse_glb();
    chk("R8 glb reset back to hunt", prog_no, 1'b1);
    chk("R8 ready after glb", lnk_ready_o, 1'b1);
  endtask

  task automatic t_stream();
    logic [7:0] pat [0:7];
    pat[0] = 8'hA5; pat[1] = 8'h3C; pat[2] = 8'h0E; pat[3] = 8'hD0;
    pat[4] = 8'h0D; pat[5] = 8'h0E; pat[6] = 8'hFF; pat[7] = 8'h00;
    go_stream();
    cap_n = 0;
    mon_bad = 0;
    for (int i = 0; i < 8; i++) send_byte(pat[i]);
    repeat (4) @(negedge clk);
    chk("R5 pulse count", cap_n, 8);
    for (int i = 0; i < 8; i++) chk("R5 byte passed unchanged", cap[i], pat[i]);
    chk("R5 setup and pulse shape", mon_bad, 0);
    chk("R5 end key in stream no effect", user_rst_no, 1'b0);
    chk("R4 cs still low", cs_no, 1'b0);
    done_i = 1'b1;
    @(negedge clk);
    chk("R6 led on", cfg_led_o, 1'b1);
    chk("R6 cs high", cs_no, 1'b1);
    chk("R6 wr high", wr_no, 1'b1);
    chk("R6 hunting ready", lnk_ready_o, 1'b1);
    send_word(32'h1122_3344);
    chk("R6 non-end word dropped", user_rst_no, 1'b0);
    chk("R5 no pulse after done", cap_n, 8);
    send_word(EKEY);
    chk("R7 user reset released", user_rst_no, 1'b1);
    chk("R7 link released", lnk_owned_o, 1'b0);
    chk("R7 ready low", lnk_ready_o, 1'b0);
  endtask

  task automatic t_glb_after_release();
    pulse_glb();
    chk("R8 user reset held", user_rst_no, 1'b0);
    chk("R8 link retaken", lnk_owned_o, 1'b1);
    chk("R8 ready", lnk_ready_o, 1'b1);
    chk("R8 led off", cfg_led_o, 1'b0);
  endtask

  task automatic t_reconf();
    reach_release();
    @(negedge clk);
    reconf_req_i = 1'b0;
    @(negedge clk);
    chk("R9 user reset held", user_rst_no, 1'b0);
    chk("R9 link retaken", lnk_owned_o, 1'b1);
    chk("R9 led off", cfg_led_o, 1'b0);
    reconf_req_i = 1'b1;
    done_i = 1'b0;
    send_word(SKEY);
    init_ni = 1'b0;
    @(negedge clk);
    chk("R9 in init wait", prog_no, 1'b1);
    reconf_req_i = 1'b0;
    @(negedge clk);
    init_ni = 1'b1;
    chk("R9 mid-handshake restart ready", lnk_ready_o, 1'b1);
    chk("R9 mid-handshake cs", cs_no, 1'b1);
    reconf_req_i = 1'b1;
    @(negedge clk);
    chk("R9 still hunting", cs_no, 1'b1);
    send_word(SKEY);
    chk("R9 start key recognised", prog_no, 1'b0);
    pulse_glb();
  endtask

  task automatic t_timeout();
    send_word(SKEY);
    repeat (TMO - 10) @(negedge clk);
    chk("R10 still waiting before limit", prog_no, 1'b0);
    chk("R10 no err yet", err_o, 1'b0);
    repeat (15) @(negedge clk);
    chk("R10 err set", err_o, 1'b1);
    chk("R10 back to hunt", prog_no, 1'b1);
    chk("R10 ready", lnk_ready_o, 1'b1);
    send_word(SKEY);
    chk("R10 err cleared", err_o, 1'b0);
    chk("R10 new start", prog_no, 1'b0);
    pulse_glb();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=hung exp=complete");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_framing();
    t_stream();
    t_glb_after_release();
    t_reconf();
    t_timeout();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule